// File: doc/BRIEF.md
# Interrupt Request Latch Register

This block holds the seven sticky interrupt request flags of a contactless transceiver controller. Event strobes and status levels arrive from the transmitter, the receiver, the command sequencer, the FIFO level comparators, the error logic and the countdown timer. The block latches each event into its own flag, and the flag stays set until host software clears it. Hardware never clears a flag.

The host reaches the flags through a simple register bus. A write chooses a group of flags with the low seven data bits. The top data bit is a mode bit: 1 sets the chosen flags and 0 clears them. A read returns the flags with the mode position read as zero. An enable mask combines the flags into one registered, active-high interrupt line.

Top module: `irq_latch_reg`

## Requirements
- R1: During synchronous reset and on the first cycle after it, the flags read 0x14 (idle and low-alert set, all others clear) and `irq_o` is 0.
- R2: Read and write bit positions are: bit 6 transmit done, bit 5 receive done, bit 4 idle, bit 3 high alert, bit 2 low alert, bit 1 error, bit 0 timer, and bit 7 is the mode bit.
- R3: A write to the register address with bit 7 = 1 sets every flag whose data bit is 1. A write with bit 7 = 0 clears every such flag. Flags whose data bit is 0 are unchanged, and only such a clearing write ever lowers a flag.
- R4: A one-cycle `tx_last_bit` strobe sets the transmit-done flag on that clock edge.
- R5: A `rx_stream_end` strobe sets the receive-done flag if `rx_noerr_mode` is 0. If `rx_noerr_mode` is 1, it sets the flag only when `fifo_nonempty` is also 1.
- R6: A 0-to-1 change of `cmd_is_idle` sets the idle flag, unless `cmd_host_write` is 1 in that same cycle (the host started Idle itself).
- R7: A 0-to-1 change of `fifo_hi_lvl` or `fifo_lo_lvl` sets the high-alert or low-alert flag. The flag stays set after the level drops. A level that is 1 on the first cycle after reset counts as a rise.
- R8: Any cycle with `err_status` nonzero sets the error flag. A `timer_zero` strobe sets the timer flag.
- R9: A read strobe returns data on `reg_rdata` one cycle later. At the register address the data is {0, flags as before the read edge}, so bit 7 is always 0. At any other address the data is 0x00.
- R10: When a hardware event and a host clear hit the same flag in the same cycle, the flag ends up set.
- R11: Writes to any address other than `REG_ADDR` (default 0x04) leave all flags unchanged.
- R12: `irq_o` is a register that holds, one cycle later, whether ({0, flags} AND `irq_en`) is nonzero. Bit 7 of `irq_en` therefore never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data, bit 7 is the set/clear mode |
| reg_rdata | output | DATA_W | Registered read data |
| irq_en | input | DATA_W | Interrupt enable mask |
| irq_o | output | 1 | Registered interrupt output, active high |
| tx_last_bit | input | 1 | Last transmitted bit has left the shifter |
| rx_stream_end | input | 1 | Receiver saw the end of a valid stream |
| rx_noerr_mode | input | 1 | Receive-no-error mode: needs FIFO data to flag |
| fifo_nonempty | input | 1 | FIFO holds at least one byte |
| cmd_is_idle | input | 1 | Command field currently holds Idle |
| cmd_host_write | input | 1 | Command field change this cycle came from the host |
| fifo_hi_lvl | input | 1 | Live FIFO high-alert level |
| fifo_lo_lvl | input | 1 | Live FIFO low-alert level |
| err_status | input | ERR_W | Error status bits |
| timer_zero | input | 1 | Countdown timer reached zero |

## Verification
The bench builds the block with its default parameters: 8-bit address and data, register at 0x04, and an 8-bit error status. With these values, writes and reads to a neighbouring address (0x05) exercise the address decode. The mask bit above the seven flags can be driven to show that it has no effect on the interrupt. Every error status bit position can also reach the error flag.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  // register bit positions of the flags
  localparam int POS_TIMER = 0;
  localparam int POS_ERR   = 1;
  localparam int POS_LO    = 2;
  localparam int POS_HI    = 3;
  localparam int POS_IDLE  = 4;
  localparam int POS_RX    = 5;
  localparam int POS_TX    = 6;
  localparam int FLAG_N    = 7;
  localparam logic [FLAG_N-1:0] FLAG_RST = 7'h14;
endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture
  import irq_latch_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_last_bit,
  input  logic              rx_stream_end,
  input  logic              rx_noerr_mode,
  input  logic              fifo_nonempty,
  input  logic              cmd_is_idle,
  input  logic              cmd_host_write,
  input  logic              fifo_hi_lvl,
  input  logic              fifo_lo_lvl,
  input  logic [ERR_W-1:0]  err_status,
  input  logic              timer_zero,
  output logic [FLAG_N-1:0] evt
);
  localparam int LVL_N = 3;

  logic [LVL_N-1:0] lvl_now;
  logic [LVL_N-1:0] lvl_prev;
  logic [LVL_N-1:0] lvl_rise;

  assign lvl_now = {cmd_is_idle, fifo_hi_lvl, fifo_lo_lvl};

  genvar g;
  generate
    for (g = 0; g < LVL_N; g++) begin : g_edge
      always_ff @(posedge clk) begin
        if (rst) lvl_prev[g] <= 1'b0;
        else     lvl_prev[g] <= lvl_now[g];
      end
      assign lvl_rise[g] = lvl_now[g] & ~lvl_prev[g];
    end
  endgenerate

  always_comb begin
    evt            = '0;
    evt[POS_TX]    = tx_last_bit;
    evt[POS_RX]    = rx_stream_end & (~rx_noerr_mode | fifo_nonempty);
    evt[POS_IDLE]  = lvl_rise[2] & ~cmd_host_write;
    evt[POS_HI]    = lvl_rise[1];
    evt[POS_LO]    = lvl_rise[0];
    evt[POS_ERR]   = |err_status;
    evt[POS_TIMER] = timer_zero;
  end
endmodule

// File: rtl/irq_flag_store.sv
module irq_flag_store #(
  parameter int          W       = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic         wr_mode,
  input  logic [W-1:0] wr_sel,
  input  logic [W-1:0] evt,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_nxt;

  always_comb begin
    flags_nxt = flags;
    if (wr_hit) begin
      if (wr_mode) flags_nxt = flags | wr_sel;
      else         flags_nxt = flags & ~wr_sel;
    end
    flags_nxt = flags_nxt | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= RST_VAL;
    else     flags <= flags_nxt;
  end

  // R10
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  // R3
  no_hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit && !wr_mode) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-2:0] flags,
  input  logic [W-1:0] irq_en,
  output logic         irq_o
);
  logic [W-1:0] flags_ext;
  assign flags_ext = {1'b0, flags};

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags_ext & irq_en);
  end

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flags) == '0) |-> !irq_o);
endmodule

// File: rtl/irq_latch_reg.sv
module irq_latch_reg
  import irq_latch_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h04,
  parameter int              ERR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] irq_en,
  output logic              irq_o,
  input  logic              tx_last_bit,
  input  logic              rx_stream_end,
  input  logic              rx_noerr_mode,
  input  logic              fifo_nonempty,
  input  logic              cmd_is_idle,
  input  logic              cmd_host_write,
  input  logic              fifo_hi_lvl,
  input  logic              fifo_lo_lvl,
  input  logic [ERR_W-1:0]  err_status,
  input  logic              timer_zero
);
  localparam int MODE_BIT = DATA_W - 1;

  logic              addr_hit;
  logic              wr_hit;
  logic [FLAG_N-1:0] evt;
  logic [FLAG_N-1:0] reg_flags;

  assign addr_hit = (reg_addr == REG_ADDR);
  assign wr_hit   = reg_wr & addr_hit;

  irq_evt_capture #(.ERR_W(ERR_W)) u_capture (
    .clk            (clk),
    .rst            (rst),
    .tx_last_bit    (tx_last_bit),
    .rx_stream_end  (rx_stream_end),
    .rx_noerr_mode  (rx_noerr_mode),
    .fifo_nonempty  (fifo_nonempty),
    .cmd_is_idle    (cmd_is_idle),
    .cmd_host_write (cmd_host_write),
    .fifo_hi_lvl    (fifo_hi_lvl),
    .fifo_lo_lvl    (fifo_lo_lvl),
    .err_status     (err_status),
    .timer_zero     (timer_zero),
    .evt            (evt)
  );

  irq_flag_store #(.W(FLAG_N), .RST_VAL(FLAG_RST)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_hit),
    .wr_mode (reg_wdata[MODE_BIT]),
    .wr_sel  (reg_wdata[FLAG_N-1:0]),
    .evt     (evt),
    .flags   (reg_flags)
  );

  irq_out_gen #(.W(DATA_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .flags  (reg_flags),
    .irq_en (irq_en),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= addr_hit ? {1'b0, reg_flags} : '0;
    end
  end

  // R7
  hi_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_hi_lvl) |=> reg_flags[POS_HI]);

  // R8
  timer_set_chk: assert property (@(posedge clk) disable iff (rst)
    timer_zero |=> reg_flags[POS_TIMER]);

  // R9
  rd_path_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && addr_hit) |=> (reg_rdata == {1'b0, $past(reg_flags)}));
endmodule

// File: tb/test_irq_latch_reg.sv
`timescale 1ns/1ps
module test_irq_latch_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata, irq_en = 0;
  logic       irq_o;
  logic       tx_last_bit = 0, rx_stream_end = 0, rx_noerr_mode = 0, fifo_nonempty = 0;
  logic       cmd_is_idle = 1, cmd_host_write = 0, fifo_hi_lvl = 0, fifo_lo_lvl = 0;
  logic [7:0] err_status = 0;
  logic       timer_zero = 0;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         mon_go = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  irq_latch_reg i_irq_latch_reg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en), .irq_o(irq_o),
    .tx_last_bit(tx_last_bit), .rx_stream_end(rx_stream_end), .rx_noerr_mode(rx_noerr_mode),
    .fifo_nonempty(fifo_nonempty), .cmd_is_idle(cmd_is_idle), .cmd_host_write(cmd_host_write),
    .fifo_hi_lvl(fifo_hi_lvl), .fifo_lo_lvl(fifo_lo_lvl), .err_status(err_status),
    .timer_zero(timer_zero)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  // monitor: pops expected read data one cycle after the read edge
  always @(negedge clk) begin
    if (mon_go) begin
      mon_go = 0;
      chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] expv, input string tag);
    reg_rd = 1; reg_addr = a;
    exp_q.push_back(expv); tag_q.push_back(tag);
    @(posedge clk);
    mon_go = 1;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {7'd0, irq_o}, 8'h00);
    rst = 0;
    tick();
    rd_reg(8'h04, 8'h14, "R1 reset value");
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);

    wr_reg(8'h04, 8'h7F);
    rd_reg(8'h04, 8'h00, "R3 clear all");

    tx_last_bit = 1; tick(); tx_last_bit = 0;
    rd_reg(8'h04, 8'h40, "R4 tx done bit6");

    rx_noerr_mode = 1; rx_stream_end = 1; tick(); rx_stream_end = 0;
    rd_reg(8'h04, 8'h40, "R5 noerr without data");
    fifo_nonempty = 1; rx_stream_end = 1; tick(); rx_stream_end = 0; fifo_nonempty = 0;
    rd_reg(8'h04, 8'h60, "R5 noerr with data");
    wr_reg(8'h04, 8'h20);
    rx_noerr_mode = 0; rx_stream_end = 1; tick(); rx_stream_end = 0;
    rd_reg(8'h04, 8'h60, "R5 normal mode");

    cmd_is_idle = 0; tick();
    cmd_is_idle = 1; cmd_host_write = 1; tick(); cmd_host_write = 0;
    rd_reg(8'h04, 8'h60, "R6 host idle start");
    cmd_is_idle = 0; tick(); cmd_is_idle = 1; tick();
    rd_reg(8'h04, 8'h70, "R6 self end");

    fifo_hi_lvl = 1; tick(); tick(); fifo_hi_lvl = 0; tick();
    rd_reg(8'h04, 8'h78, "R7 hi alert sticky");
    wr_reg(8'h04, 8'h08);
    rd_reg(8'h04, 8'h70, "R7 hi cleared");
    fifo_lo_lvl = 1; tick(); fifo_lo_lvl = 0;
    rd_reg(8'h04, 8'h74, "R7 lo alert");

    wr_reg(8'h04, 8'h83);
    rd_reg(8'h04, 8'h77, "R2 R3 R9 set mode, bit7 reads 0");
    wr_reg(8'h04, 8'h03);
    rd_reg(8'h04, 8'h74, "R3 clear group");

    err_status = 8'h10; tick(); err_status = 0;
    rd_reg(8'h04, 8'h76, "R8 error");
    timer_zero = 1; tick(); timer_zero = 0;
    rd_reg(8'h04, 8'h77, "R8 timer");

    repeat (20) tick();
    rd_reg(8'h04, 8'h77, "R3 flags hold");

    err_status = 8'h01; wr_reg(8'h04, 8'h02); err_status = 0;
    rd_reg(8'h04, 8'h77, "R10 set beats clear");
    wr_reg(8'h04, 8'h02);
    rd_reg(8'h04, 8'h75, "R10 later clear");

    wr_reg(8'h05, 8'h7F);
    rd_reg(8'h05, 8'h00, "R9 other address reads 0");
    rd_reg(8'h04, 8'h75, "R11 other address ignored");

    chk("R12 mask zero", {7'd0, irq_o}, 8'h00);
    irq_en = 8'h80; tick();
    chk("R12 bit7 mask", {7'd0, irq_o}, 8'h00);
    irq_en = 8'h01; tick();
    chk("R12 timer enabled", {7'd0, irq_o}, 8'h01);
    wr_reg(8'h04, 8'h01);
    chk("R12 registered delay", {7'd0, irq_o}, 8'h01);
    tick();
    chk("R12 drop after clear", {7'd0, irq_o}, 8'h00);

    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule